// File: doc/BRIEF.md
# Prime-modulus bank address mapper

The mapper turns a flat word address into a coordinate for an interleaved memory whose bank count is a Mersenne-form number, 2^M − 1, while each bank holds a power-of-two number of words. The bank index is the address taken modulo 2^M − 1. The offset inside the bank is the address taken modulo the bank depth. Because an odd bank count and a power-of-two depth share no factor, every address below the product of the two lands on its own (bank, offset) pair. Strided access patterns that would pile onto one bank in a power-of-two interleave are spread across all banks.

No divider is used. Each address bit k contributes the fixed residue 2^(k mod M). These terms are summed into a small word. That word is then folded repeatedly, with its high part added back onto its low M bits, until it fits in M bits. An all-ones result is congruent to zero and is output as zero. The offset is simply the low address bits. One register stage sits between the arithmetic and the outputs.

Both sides of the stage are valid/ready streams. An address is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed on at an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While a result waits with `out_ready` low, it stays fixed and no new address is accepted.

Top module: `bankmap_mersenne`

## Requirements
- R1: For every accepted address A, the result carries out_bank = A mod (2^M − 1).
- R2: out_bank always lies in 0 .. 2^M − 2. An address congruent to zero, such as 2^M − 1 or the all-ones address of 12 bits with M = 3, gives bank 0 and never the all-ones code.
- R3: out_offset equals the low OFS_W bits of the accepted address, which is A mod 2^OFS_W.
- R4: Over the addresses 0 .. (2^M − 1)·2^OFS_W − 1, every (bank, offset) pair is produced exactly once.
- R5: An address accepted at a clock edge appears on the outputs with out_valid high right after that edge, which is a latency of one cycle.
- R6: While out_valid is high and out_ready is low, out_valid, out_bank and out_offset hold their values.
- R7: in_ready is high exactly when out_valid is low or out_ready is high. Each accepted address yields exactly one result, and results leave in the order of acceptance.
- R8: While rst is high, and in the first cycle after it is released, out_valid is low.
- R9: With out_ready held high and in_valid high on every cycle, one result is delivered on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An address is offered |
| in_ready | output | 1 | The mapper takes the offered address at this edge |
| in_addr | input | ADDR_W (12) | Word address |
| out_valid | output | 1 | A mapped result is present |
| out_ready | input | 1 | The consumer takes the result at this edge |
| out_bank | output | M (3) | Bank index, A mod (2^M − 1) |
| out_offset | output | OFS_W (4) | Word offset inside the bank, A mod 2^OFS_W |

## Verification
A dense sweep over the whole one-to-one range, with the consumer always ready, exercises the residue arithmetic on each address and shows whether pairs collide (R4). The same sweep checks that the mapper accepts a new address on every cycle. Single-bit addresses and multiples of 2^M − 1 (including the all-ones address) check the residue of each bit position and the conversion of the all-ones code to zero. Random addresses under random valid and ready patterns compare the stall-and-hold behaviour and the ordering against a behavioural model on every clock.

// File: rtl/bm_pkg.sv
package bm_pkg;

  // Residue of the single-bit value 2^k modulo (2^m - 1): 2^(k mod m).
  function automatic int unsigned bit_residue(input int unsigned k, input int unsigned m);
    return 32'd1 << (k % m);
  endfunction

  // Width needed to hold the sum of n residues each below 2^m.
  function automatic int unsigned sum_width(input int unsigned n, input int unsigned m);
    return m + $clog2(n + 1);
  endfunction

endpackage

// File: rtl/bm_fold.sv
module bm_fold #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned M      = 3,
  localparam int unsigned SUM_W = bm_pkg::sum_width(ADDR_W, M)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SUM_W-1:0]  sum
);

  logic [SUM_W-1:0] term [ADDR_W];

  // One residue term per address bit.
  for (genvar k = 0; k < ADDR_W; k++) begin : g_term
    localparam logic [SUM_W-1:0] RES = SUM_W'(bm_pkg::bit_residue(k, M));
    assign term[k] = addr[k] ? RES : '0;
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < ADDR_W; k++) begin
      sum = sum + term[k];
    end
  end

endmodule

// File: rtl/bm_reduce.sv
module bm_reduce #(
  parameter int unsigned SUM_W = 7,
  parameter int unsigned M     = 3,
  localparam int unsigned NPASS = SUM_W
) (
  input  logic [SUM_W-1:0] sum,
  output logic [M-1:0]     bank
);

  logic [SUM_W-1:0] stg [NPASS+1];
  logic [M-1:0]     low;

  assign stg[0] = sum;

  // Each pass adds the high part back onto the low M bits (2^M == 1 mod Nb).
  for (genvar p = 0; p < NPASS; p++) begin : g_pass
    assign stg[p+1] = SUM_W'(stg[p][M-1:0]) + (stg[p] >> M);
  end

  assign low  = stg[NPASS][M-1:0];
  // All ones equals Nb, which is congruent to zero.
  assign bank = (low == {M{1'b1}}) ? '0 : low;

endmodule

// File: rtl/bm_stage.sv
module bm_stage #(
  parameter int unsigned DW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);

  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s_ready && s_valid) begin
      m_data <= s_data;
    end
  end

  // R6: a waiting result is held
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R5: an accepted item is presented on the next cycle
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> m_valid);

  // R7: a result that is taken with no new input leaves the register empty
  p_drain_r7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && !s_valid) |=> !m_valid);

endmodule

// File: rtl/bankmap_mersenne.sv
module bankmap_mersenne #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned M      = 3,
  parameter int unsigned OFS_W  = 4,
  localparam int unsigned SUM_W = bm_pkg::sum_width(ADDR_W, M),
  localparam int unsigned DW    = M + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [M-1:0]      out_bank,
  output logic [OFS_W-1:0]  out_offset
);

  logic [SUM_W-1:0] res_sum;
  logic [M-1:0]     bank_c;
  logic [DW-1:0]    q_data;

  bm_fold #(.ADDR_W(ADDR_W), .M(M)) u_fold (
    .addr (in_addr),
    .sum  (res_sum)
  );

  bm_reduce #(.SUM_W(SUM_W), .M(M)) u_reduce (
    .sum  (res_sum),
    .bank (bank_c)
  );

  bm_stage #(.DW(DW)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  ({bank_c, in_addr[OFS_W-1:0]}),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (q_data)
  );

  assign out_bank   = q_data[DW-1:OFS_W];
  assign out_offset = q_data[OFS_W-1:0];

  // R2: the all-ones code never leaves the block
  p_bank_range_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bank != {M{1'b1}}));

  // R3: the offset is the low bits of the address accepted one cycle earlier
  p_offset_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_offset == $past(in_addr[OFS_W-1:0])));

endmodule

// File: tb/bankmap_mersenne_tb.sv
module bankmap_mersenne_tb;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int M      = 3;
  localparam int OFS_W  = 4;
  localparam int NB     = (1 << M) - 1;
  localparam int NW     = 1 << OFS_W;
  localparam int SPAN   = NB * NW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ADDR_W-1:0] in_addr = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [M-1:0]      out_bank;
  logic [OFS_W-1:0]  out_offset;

  int vectors = 0;
  int fails   = 0;
  bit sweep   = 0;
  bit mv = 0;
  int mb = 0, mo = 0, ma = 0;
  bit stalled = 0;
  bit post_rst = 0;
  int seen [SPAN];

  always #(PERIOD/2) clk = ~clk;

  bankmap_mersenne #(.ADDR_W(ADDR_W), .M(M), .OFS_W(OFS_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_bank(out_bank), .out_offset(out_offset)
  );

  // Behavioural reference: a one-entry holding slot.
  always @(posedge clk) begin
    post_rst <= rst;
    if (rst) begin
      mv <= 0;
      stalled <= 0;
    end else begin
      stalled <= mv && !out_ready;
      if (!mv || out_ready) begin
        mv <= in_valid;
        if (in_valid) begin
          ma <= int'(in_addr);
          mb <= int'(in_addr) % NB;
          mo <= int'(in_addr) % NW;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst || post_rst) begin
      chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
    end else begin
      chk(in_ready == (!mv || out_ready), "R7", int'(in_ready), int'(!mv || out_ready));
      chk(out_valid == mv, sweep ? "R9" : "R5", int'(out_valid), int'(mv));
      if (mv && out_valid) begin
        chk(int'(out_bank) == mb, stalled ? "R6" : "R1", int'(out_bank), mb);
        chk(int'(out_offset) == mo, "R3", int'(out_offset), mo);
        chk(int'(out_bank) < NB, "R2", int'(out_bank), NB - 1);
        if (out_ready && sweep && ma < SPAN)
          seen[int'(out_bank) * NW + int'(out_offset)]++;
      end
    end
  end

  task automatic drive(input bit v, input int a, input bit r);
    @(posedge clk);
    #1;
    in_valid  = v;
    in_addr   = ADDR_W'(a);
    out_ready = r;
  endtask

  // Offer one address and keep it until the bench's own slot model accepts it.
  task automatic offer(input int a, input bit r);
    bit taken;
    taken = 0;
    while (!taken) begin
      drive(1'b1, a, r);
      taken = (!mv || out_ready);
      r = ($urandom % 3) != 0;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < SPAN; i++) seen[i] = 0;
    repeat (4) drive(1'b1, 5, 1'b1);
    drive(1'b0, 0, 1'b1);
    rst = 1'b0;
    drive(1'b0, 0, 1'b1);
    // R4 / R9: dense sweep, consumer always ready
    sweep = 1;
    for (int a = 0; a < SPAN; a++) drive(1'b1, a, 1'b1);
    drive(1'b0, 0, 1'b1);
    drive(1'b0, 0, 1'b1);
    sweep = 0;
    for (int i = 0; i < SPAN; i++)
      chk(seen[i] == 1, "R4", seen[i], 1);
    // R2 / R1: single bits, multiples of NB, all ones
    for (int k = 0; k < ADDR_W; k++) drive(1'b1, 1 << k, 1'b1);
    for (int j = 1; j < 40; j++) drive(1'b1, (j * NB * 13) % (1 << ADDR_W), 1'b1);
    drive(1'b1, (1 << ADDR_W) - 1, 1'b1);
    drive(1'b1, NB, 1'b1);
    drive(1'b1, (1 << ADDR_W) - 2, 1'b1);
    // R6 / R7: long stall then release
    drive(1'b1, 1234, 1'b0);
    repeat (5) drive(1'b1, 999, 1'b0);
    drive(1'b0, 0, 1'b1);
    // random traffic with back-pressure
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 4) == 0) drive(1'b0, 0, ($urandom % 2) == 1);
      else offer(int'($urandom % (1 << ADDR_W)), ($urandom % 3) != 0);
    end
    repeat (4) drive(1'b0, 0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule